// File: doc/BRIEF.md
# Tile power-gating handshake controller

This block sequences the power-down of a single processor tile under software control through a 32-bit register interface. Software first asks for a prepare phase. The controller answers with an acknowledge and, in the same register, a set of per-cause error flags. If a wake source is active when the request is evaluated, the prepare is aborted and flagged. Once the tile is prepared without errors, software asks for the gate phase and arms the controller. Power is removed only after the core then reports that it has halted.

While the tile is gated, an enabled wake event starts a fixed release delay, set by a parameter. At the end of that delay the gate is dropped and all request and acknowledge bits are cleared. A warm-reset flag is set, and a one-cycle pulse tells the core to fetch the stored 64-bit resume address. Both phases have a disable request. Software uses it to back out of a prepared or armed state and receives a separate acknowledge. A wake-mask register selects which wake lines count, and it has its own request and acknowledge.

Registers are write-only-on-strobe and read combinationally. Offsets are: prepare 0x00, gate 0x04, resume low 0x10, resume high 0x14, wake mask 0x20.

Top module: `tile_pg_ctrl`

## Requirements
- R1: After reset, `pgEnable` and `resumeValid` are 0 and the registers at 0x00, 0x04, 0x10 and 0x14 read 0. The wake-mask register reads all mask bits set (0x0000000F for four wake lines), with bits 31 and 30 clear.
- R2: Writing 0x00 with bit 31 set posts a prepare request. The request reads back in bit 31 until the next clock edge. On that edge bit 31 clears and the acknowledge in bit 30 sets. Any write with bit 31 or bit 29 set clears that register's acknowledges in bits 30 and 28.
- R3: When a prepare request is evaluated, the controller records which error inputs are high in the prepare register. `clusterBusy` goes to bit 18, `pmEnaErr` to bit 17, `pmDeny` to bit 16 and `busErr` to bit 15. Any flag set leaves the tile unprepared, so a later gate request never leads to `pgEnable`. A new prepare request clears the flags.
- R4: If an enabled wake line (`wakeEvt` AND mask) is high when a prepare request is evaluated, bit 2 (abort) and bit 12 (wake seen) set and the tile is not prepared. A wake line whose mask bit is 0 has no effect.
- R5: Writing 0x00 with bit 29 set cancels the prepared or armed state. Bit 28 sets one edge later. The error flags are kept.
- R6: Writing 0x04 with bit 31 set posts a gate request, acknowledged in bit 30 one edge later. The controller arms only if the tile is prepared with no prepare flag and no enabled wake. It records `pmEnaErr`, `pmDeny`, `busErr` and `masterBusy` in bits 17, 16, 15 and 14 of 0x04, and any of them blocks arming.
- R7: `pgEnable` rises on the first clock edge at which `coreHalted` is sampled high while the controller is armed. It never rises otherwise.
- R8: An enabled wake after prepare and before the gate is applied sets bit 12 of 0x00 and disarms. Halting afterwards does not apply the gate.
- R9: Writing 0x04 with bit 29 set disarms without gating and sets bit 28 of 0x04 one edge later.
- R10: With the gate applied, an enabled wake sampled at edge E keeps `pgEnable` high through edge E+WAKE_DELAY-1 and drops it at edge E+WAKE_DELAY. `resumeValid` is high for exactly the cycle that follows that edge. At the same edge all request and acknowledge bits of 0x00 and 0x04 clear, and bit 1 (warm reset) of 0x04 sets.
- R11: Words written at 0x10 and 0x14 read back and drive `resumeAddr` as {high, low}. A high word never written stays 0.
- R12: Writing 0x20 with bit 31 set stores the low mask bits as pending, sets bit 31 and clears bit 30. One edge later the mask takes the pending value, bit 31 clears and bit 30 sets. A write to 0x20 with bit 31 clear is ignored.
- R13: A new gate request write clears the warm-reset bit and the gate error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register byte offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` |
| wakeEvt | input | NUM_WAKE | Wake event lines |
| pmEnaErr | input | 1 | Power manager reports an enable error |
| pmDeny | input | 1 | Power manager denies the request |
| busErr | input | 1 | Bus error during the handshake |
| clusterBusy | input | 1 | Cluster port not quiescent |
| masterBusy | input | 1 | Tile master port not quiescent |
| coreHalted | input | 1 | Core has executed its halt |
| pgEnable | output | 1 | Power-gate enable to the switches |
| resumeAddr | output | 64 | Stored resume address |
| resumeValid | output | 1 | One-cycle pulse: core may resume at `resumeAddr` |

## Verification
The gating sequence is run through several distinct patterns. One is a clean prepare, arm, halt and wake, with the release delay counted edge by edge. Others are a prepare with several error inputs high at once, a prepare hit by a masked-in wake versus a masked-out wake, and a wake arriving between prepare and halt. Gate requests are made with power-manager and port errors, and an armed gate is cancelled. Comparing the exact flag words read back tells apart which cause was latched and at which phase. The `pgEnable` level after a halt separates armed from merely acknowledged states.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  localparam logic [7:0] OFS_PREP   = 8'h00;
  localparam logic [7:0] OFS_GATE   = 8'h04;
  localparam logic [7:0] OFS_RES_LO = 8'h10;
  localparam logic [7:0] OFS_RES_HI = 8'h14;
  localparam logic [7:0] OFS_MASK   = 8'h20;

  // handshake field positions shared by the prepare and gate registers
  localparam int B_EN_REQ  = 31;
  localparam int B_EN_ACK  = 30;
  localparam int B_DIS_REQ = 29;
  localparam int B_DIS_ACK = 28;
  // cause flags
  localparam int B_PORT_BUSY = 18;
  localparam int B_ENA_ERR   = 17;
  localparam int B_DENY      = 16;
  localparam int B_BUS_ERR   = 15;
  localparam int B_MST_BUSY  = 14;
  localparam int B_WAKE_SEEN = 12;
  localparam int B_ABORT     = 2;
  localparam int B_WARM      = 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PREPPED, ST_ARMED, ST_GATED, ST_WAKING
  } tpgState_t;

  typedef struct packed {
    logic prepEn;
    logic prepDis;
    logic gateEn;
    logic gateDis;
  } tpgReq_t;

  typedef struct packed {
    logic ackPrepEn;
    logic ackPrepDis;
    logic ackGateEn;
    logic ackGateDis;
    logic latchPrep;
    logic prepAbort;
    logic latchGate;
    logic setWake;
    logic wakeDone;
  } tpgStrobe_t;

endpackage

// File: rtl/tpg_regs.sv
module tpg_regs
  import tpg_pkg::*;
#(
  parameter int NUM_WAKE = 4,
  parameter int REG_AW   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [REG_AW-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic                clusterBusy,
  input  logic                masterBusy,
  input  logic                pmEnaErr,
  input  logic                pmDeny,
  input  logic                busErr,
  input  tpgStrobe_t          strobe,
  output tpgReq_t             req,
  output logic                prepFlagAny,
  output logic [NUM_WAKE-1:0] wakeMask,
  output logic [63:0]         resumeAddr
);

  logic prepEnReq, prepEnAck, prepDisReq, prepDisAck;
  logic pPortBusy, pEnaErr, pDeny, pBusErr, pWake, pAbort;
  logic gEnReq, gEnAck, gDisReq, gDisAck;
  logic gEnaErr, gDeny, gBusErr, gMstBusy, gWarm;
  logic [31:0] resumeLo, resumeHi;
  logic maskReq, maskAck;
  logic [NUM_WAKE-1:0] maskPend, mask;

  logic wrPrep, wrGate, wrLo, wrHi, wrMask;
  assign wrPrep = wrEn && (addr == REG_AW'(OFS_PREP));
  assign wrGate = wrEn && (addr == REG_AW'(OFS_GATE));
  assign wrLo   = wrEn && (addr == REG_AW'(OFS_RES_LO));
  assign wrHi   = wrEn && (addr == REG_AW'(OFS_RES_HI));
  assign wrMask = wrEn && (addr == REG_AW'(OFS_MASK));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prepEnReq <= 1'b0; prepEnAck <= 1'b0; prepDisReq <= 1'b0; prepDisAck <= 1'b0;
      pPortBusy <= 1'b0; pEnaErr <= 1'b0; pDeny <= 1'b0; pBusErr <= 1'b0;
      pWake <= 1'b0; pAbort <= 1'b0;
      gEnReq <= 1'b0; gEnAck <= 1'b0; gDisReq <= 1'b0; gDisAck <= 1'b0;
      gEnaErr <= 1'b0; gDeny <= 1'b0; gBusErr <= 1'b0; gMstBusy <= 1'b0; gWarm <= 1'b0;
      resumeLo <= '0; resumeHi <= '0;
      maskReq <= 1'b0; maskAck <= 1'b0; maskPend <= '1; mask <= '1;
    end else begin
      // responses from the sequencer for requests posted earlier
      if (strobe.ackPrepEn)  begin prepEnReq  <= 1'b0; prepEnAck  <= 1'b1; end
      if (strobe.ackPrepDis) begin prepDisReq <= 1'b0; prepDisAck <= 1'b1; end
      if (strobe.ackGateEn)  begin gEnReq     <= 1'b0; gEnAck     <= 1'b1; end
      if (strobe.ackGateDis) begin gDisReq    <= 1'b0; gDisAck    <= 1'b1; end
      if (strobe.latchPrep) begin
        pPortBusy <= clusterBusy;
        pEnaErr   <= pmEnaErr;
        pDeny     <= pmDeny;
        pBusErr   <= busErr;
        pWake     <= strobe.prepAbort;
        pAbort    <= strobe.prepAbort;
      end
      if (strobe.setWake) pWake <= 1'b1;
      if (strobe.latchGate) begin
        gEnaErr  <= pmEnaErr;
        gDeny    <= pmDeny;
        gBusErr  <= busErr;
        gMstBusy <= masterBusy;
      end
      if (strobe.wakeDone) begin
        prepEnReq <= 1'b0; prepEnAck <= 1'b0; prepDisReq <= 1'b0; prepDisAck <= 1'b0;
        gEnReq    <= 1'b0; gEnAck    <= 1'b0; gDisReq    <= 1'b0; gDisAck    <= 1'b0;
        gWarm     <= 1'b1;
      end
      if (maskReq) begin
        mask    <= maskPend;
        maskReq <= 1'b0;
        maskAck <= 1'b1;
      end
      // new writes take precedence over responses in the same cycle
      if (wrPrep && (wdata[B_EN_REQ] || wdata[B_DIS_REQ])) begin
        prepEnAck <= 1'b0; prepDisAck <= 1'b0;
      end
      if (wrPrep && wdata[B_EN_REQ]) begin
        prepEnReq <= 1'b1;
        pPortBusy <= 1'b0; pEnaErr <= 1'b0; pDeny <= 1'b0; pBusErr <= 1'b0;
        pWake <= 1'b0; pAbort <= 1'b0;
      end
      if (wrPrep && wdata[B_DIS_REQ]) prepDisReq <= 1'b1;
      if (wrGate && (wdata[B_EN_REQ] || wdata[B_DIS_REQ])) begin
        gEnAck <= 1'b0; gDisAck <= 1'b0;
      end
      if (wrGate && wdata[B_EN_REQ]) begin
        gEnReq <= 1'b1;
        gEnaErr <= 1'b0; gDeny <= 1'b0; gBusErr <= 1'b0; gMstBusy <= 1'b0; gWarm <= 1'b0;
      end
      if (wrGate && wdata[B_DIS_REQ]) gDisReq <= 1'b1;
      if (wrLo) resumeLo <= wdata;
      if (wrHi) resumeHi <= wdata;
      if (wrMask && wdata[B_EN_REQ]) begin
        maskPend <= wdata[NUM_WAKE-1:0];
        maskReq  <= 1'b1;
        maskAck  <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == REG_AW'(OFS_PREP)) begin
      rdata[B_EN_REQ] = prepEnReq;   rdata[B_EN_ACK] = prepEnAck;
      rdata[B_DIS_REQ] = prepDisReq; rdata[B_DIS_ACK] = prepDisAck;
      rdata[B_PORT_BUSY] = pPortBusy; rdata[B_ENA_ERR] = pEnaErr;
      rdata[B_DENY] = pDeny;          rdata[B_BUS_ERR] = pBusErr;
      rdata[B_WAKE_SEEN] = pWake;     rdata[B_ABORT] = pAbort;
    end else if (addr == REG_AW'(OFS_GATE)) begin
      rdata[B_EN_REQ] = gEnReq;   rdata[B_EN_ACK] = gEnAck;
      rdata[B_DIS_REQ] = gDisReq; rdata[B_DIS_ACK] = gDisAck;
      rdata[B_ENA_ERR] = gEnaErr; rdata[B_DENY] = gDeny;
      rdata[B_BUS_ERR] = gBusErr; rdata[B_MST_BUSY] = gMstBusy;
      rdata[B_WARM] = gWarm;
    end else if (addr == REG_AW'(OFS_RES_LO)) begin
      rdata = resumeLo;
    end else if (addr == REG_AW'(OFS_RES_HI)) begin
      rdata = resumeHi;
    end else if (addr == REG_AW'(OFS_MASK)) begin
      rdata[B_EN_REQ] = maskReq;
      rdata[B_EN_ACK] = maskAck;
      rdata[NUM_WAKE-1:0] = mask;
    end
  end

  always_comb begin
    req.prepEn  = prepEnReq;
    req.prepDis = prepDisReq;
    req.gateEn  = gEnReq;
    req.gateDis = gDisReq;
  end

  assign prepFlagAny = pPortBusy | pEnaErr | pDeny | pBusErr | pWake;
  assign wakeMask    = mask;
  assign resumeAddr  = {resumeHi, resumeLo};

  // R2: a posted prepare request is answered on the very next edge
  assert_req_selfclear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (prepEnReq && !(wrPrep && wdata[B_EN_REQ])) |=> !prepEnReq);

  // R2: a request only disappears by being acknowledged or by a wake release
  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(prepEnReq) |-> (prepEnAck || gWarm));

  // R12: a mask update completes in one edge
  assert_mask_ack_R12: assert property (@(posedge clk) disable iff (!rstN)
    (maskReq && !(wrMask && wdata[B_EN_REQ])) |=> (maskAck && !maskReq));

endmodule

// File: rtl/tpg_ctrl.sv
module tpg_ctrl
  import tpg_pkg::*;
#(
  parameter int NUM_WAKE   = 4,
  parameter int WAKE_DELAY = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  tpgReq_t             req,
  input  logic                prepFlagAny,
  input  logic [NUM_WAKE-1:0] wakeEvt,
  input  logic [NUM_WAKE-1:0] wakeMask,
  input  logic                coreHalted,
  input  logic                clusterBusy,
  input  logic                masterBusy,
  input  logic                pmEnaErr,
  input  logic                pmDeny,
  input  logic                busErr,
  output tpgStrobe_t          strobe,
  output logic                pgEnable,
  output logic                resumeValid
);

  localparam int CNT_W = $clog2(WAKE_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_DELAY - 1);

  tpgState_t state, nextState;
  logic [CNT_W-1:0] cnt;
  logic wakeHit, prepErr, gateErr, live;

  assign wakeHit = |(wakeEvt & wakeMask);
  assign prepErr = clusterBusy | pmEnaErr | pmDeny | busErr;
  assign gateErr = masterBusy | pmEnaErr | pmDeny | busErr;
  assign live    = (state == ST_IDLE) || (state == ST_PREPPED) || (state == ST_ARMED);

  always_comb begin
    strobe    = '0;
    nextState = state;
    // every posted request is acknowledged on the next edge
    strobe.ackPrepEn  = req.prepEn;
    strobe.ackPrepDis = req.prepDis;
    strobe.ackGateEn  = req.gateEn;
    strobe.ackGateDis = req.gateDis;
    if (live) begin
      strobe.latchPrep = req.prepEn;
      strobe.prepAbort = req.prepEn && wakeHit;
      strobe.latchGate = req.gateEn;
      strobe.setWake   = wakeHit && (state != ST_IDLE) && !req.prepEn && !req.prepDis;
      if (req.prepDis)
        nextState = ST_IDLE;
      else if (req.prepEn)
        nextState = (wakeHit || prepErr) ? ST_IDLE : ST_PREPPED;
      else if (req.gateDis && (state == ST_ARMED))
        nextState = ST_PREPPED;
      else if (req.gateEn && (state != ST_IDLE))
        nextState = (!prepFlagAny && !gateErr && !wakeHit) ? ST_ARMED : ST_PREPPED;
      else if ((state == ST_ARMED) && wakeHit)
        nextState = ST_PREPPED;
      else if ((state == ST_ARMED) && coreHalted)
        nextState = ST_GATED;
    end else if (state == ST_GATED) begin
      if (wakeHit) nextState = ST_WAKING;
    end else begin
      if (cnt == CNT_LAST) begin
        nextState       = ST_IDLE;
        strobe.wakeDone = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      resumeValid <= 1'b0;
    end else begin
      state       <= nextState;
      resumeValid <= strobe.wakeDone;
      if (state == ST_WAKING)   cnt <= cnt + 1'b1;
      else                      cnt <= '0;
    end
  end

  assign pgEnable = (state == ST_GATED) || (state == ST_WAKING);

  // R7: power is only removed after a sampled halt
  assert_gate_after_halt_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgEnable) |-> $past(coreHalted));

  // R8: a wake between prepare and gate keeps the gate off
  assert_wake_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_PREPPED || state == ST_ARMED) && wakeHit) |=> !pgEnable);

  // R10: the release counter never passes the programmed delay
  assert_wake_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAKING) |-> (int'(cnt) < WAKE_DELAY));

  // R10: the resume pulse coincides with the gate release
  assert_resume_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    resumeValid |-> (!pgEnable && $past(pgEnable)));

endmodule

// File: rtl/tile_pg_ctrl.sv
module tile_pg_ctrl
  import tpg_pkg::*;
#(
  parameter int NUM_WAKE   = 4,
  parameter int WAKE_DELAY = 4,
  parameter int REG_AW     = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic [NUM_WAKE-1:0] wakeEvt,
  input  logic                pmEnaErr,
  input  logic                pmDeny,
  input  logic                busErr,
  input  logic                clusterBusy,
  input  logic                masterBusy,
  input  logic                coreHalted,
  output logic                pgEnable,
  output logic [63:0]         resumeAddr,
  output logic                resumeValid
);

  tpgStrobe_t strobe;
  tpgReq_t req;
  logic prepFlagAny;
  logic [NUM_WAKE-1:0] wakeMask;

  tpg_regs #(.NUM_WAKE(NUM_WAKE), .REG_AW(REG_AW)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr), .wdata(regWdata),
    .rdata(regRdata), .clusterBusy(clusterBusy), .masterBusy(masterBusy),
    .pmEnaErr(pmEnaErr), .pmDeny(pmDeny), .busErr(busErr), .strobe(strobe),
    .req(req), .prepFlagAny(prepFlagAny), .wakeMask(wakeMask), .resumeAddr(resumeAddr)
  );

  tpg_ctrl #(.NUM_WAKE(NUM_WAKE), .WAKE_DELAY(WAKE_DELAY)) uCtrl (
    .clk(clk), .rstN(rstN), .req(req), .prepFlagAny(prepFlagAny),
    .wakeEvt(wakeEvt), .wakeMask(wakeMask), .coreHalted(coreHalted),
    .clusterBusy(clusterBusy), .masterBusy(masterBusy), .pmEnaErr(pmEnaErr),
    .pmDeny(pmDeny), .busErr(busErr), .strobe(strobe), .pgEnable(pgEnable),
    .resumeValid(resumeValid)
  );

endmodule

// File: tb/tile_pg_ctrl_test.sv
`timescale 1ns/10ps
module tile_pg_ctrl_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0] wakeEvt = '0;
  logic pmEnaErr = 1'b0, pmDeny = 1'b0, busErr = 1'b0;
  logic clusterBusy = 1'b0, masterBusy = 1'b0, coreHalted = 1'b0;
  logic pgEnable, resumeValid;
  logic [63:0] resumeAddr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tile_pg_ctrl #(.NUM_WAKE(4), .WAKE_DELAY(4), .REG_AW(8)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .wakeEvt(wakeEvt), .pmEnaErr(pmEnaErr), .pmDeny(pmDeny),
    .busErr(busErr), .clusterBusy(clusterBusy), .masterBusy(masterBusy),
    .coreHalted(coreHalted), .pgEnable(pgEnable), .resumeAddr(resumeAddr),
    .resumeValid(resumeValid)
  );

  // ins = {coreHalted, masterBusy, clusterBusy, busErr, pmDeny, pmEnaErr, wakeEvt[3:0]}
  typedef struct packed {
    logic [1:0]  kind;   // 0 write, 1 idle edge, 2 check
    logic [9:0]  ins;
    logic [7:0]  a;
    logic [31:0] d;      // write data or expected read value
    logic        pg;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [0:NV-1] = '{
    '{2'd0, 10'h000, 8'h00, 32'h80000000, 1'b0, 4'd2},
    '{2'd1, 10'h000, 8'h00, 32'h0,        1'b0, 4'd2},
    '{2'd2, 10'h000, 8'h00, 32'h40000000, 1'b0, 4'd2},  // R2 prepare ack
    '{2'd0, 10'h000, 8'h04, 32'h80000000, 1'b0, 4'd6},
    '{2'd1, 10'h000, 8'h00, 32'h0,        1'b0, 4'd6},
    '{2'd2, 10'h000, 8'h04, 32'h40000000, 1'b0, 4'd6},  // R6 gate ack, armed
    '{2'd1, 10'h200, 8'h00, 32'h0,        1'b0, 4'd7},
    '{2'd2, 10'h200, 8'h04, 32'h40000000, 1'b1, 4'd7},  // R7 halt applies gate
    '{2'd1, 10'h201, 8'h00, 32'h0,        1'b1, 4'd10},
    '{2'd1, 10'h200, 8'h00, 32'h0,        1'b1, 4'd10},
    '{2'd1, 10'h200, 8'h00, 32'h0,        1'b1, 4'd10},
    '{2'd1, 10'h200, 8'h00, 32'h0,        1'b1, 4'd10},
    '{2'd2, 10'h200, 8'h04, 32'h40000000, 1'b1, 4'd10}, // R10 still gated at E+3
    '{2'd1, 10'h200, 8'h00, 32'h0,        1'b0, 4'd10},
    '{2'd2, 10'h200, 8'h04, 32'h00000002, 1'b0, 4'd10}, // R10 released, warm set
    '{2'd2, 10'h200, 8'h00, 32'h00000000, 1'b0, 4'd10}, // R10 prepare bits cleared
    '{2'd0, 10'h000, 8'h00, 32'h80000000, 1'b0, 4'd3},
    '{2'd1, 10'h0C0, 8'h00, 32'h0,        1'b0, 4'd3},
    '{2'd2, 10'h000, 8'h00, 32'h40048000, 1'b0, 4'd3},  // R3 port busy + bus error
    '{2'd0, 10'h000, 8'h04, 32'h80000000, 1'b0, 4'd13},
    '{2'd1, 10'h000, 8'h00, 32'h0,        1'b0, 4'd13},
    '{2'd2, 10'h000, 8'h04, 32'h40000000, 1'b0, 4'd13}, // R13 warm cleared
    '{2'd1, 10'h200, 8'h00, 32'h0,        1'b0, 4'd3},
    '{2'd2, 10'h200, 8'h04, 32'h40000000, 1'b0, 4'd3},  // R3 no gate after error
    '{2'd0, 10'h000, 8'h00, 32'h20000000, 1'b0, 4'd5},
    '{2'd1, 10'h000, 8'h00, 32'h0,        1'b0, 4'd5},
    '{2'd2, 10'h000, 8'h00, 32'h10048000, 1'b0, 4'd5},  // R5 disable ack, flags kept
    '{2'd0, 10'h000, 8'h00, 32'h80000000, 1'b0, 4'd4},
    '{2'd1, 10'h002, 8'h00, 32'h0,        1'b0, 4'd4},
    '{2'd2, 10'h000, 8'h00, 32'h40001004, 1'b0, 4'd4}   // R4 abort on wake
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [9:0] ins, input logic wr, input logic [7:0] a,
                      input logic [31:0] d);
    @(negedge clk);
    {coreHalted, masterBusy, clusterBusy, busErr, pmDeny, pmEnaErr, wakeEvt} = ins;
    regWrEn = wr; regAddr = a; regWdata = d;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic chkReg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    regAddr = a;
    #0.1;
    chk(tag, {32'h0, regRdata}, {32'h0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #0.5;
    // R1 reset state
    chk("R1 pgEnable", {63'h0, pgEnable}, 64'h0);
    chk("R1 resumeValid", {63'h0, resumeValid}, 64'h0);
    chkReg("R1 prep", 8'h00, 32'h0);
    chkReg("R1 gate", 8'h04, 32'h0);
    chkReg("R1 resume hi", 8'h14, 32'h0);
    chkReg("R1 mask", 8'h20, 32'h0000000F);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].kind)
        2'd0: step(VEC[i].ins, 1'b1, VEC[i].a, VEC[i].d);
        2'd1: step(VEC[i].ins, 1'b0, 8'h00, 32'h0);
        default: begin
          chkReg($sformatf("R%0d table row %0d reg", VEC[i].req, i), VEC[i].a, VEC[i].d);
          chk($sformatf("R%0d table row %0d pg", VEC[i].req, i), {63'h0, pgEnable},
              {63'h0, VEC[i].pg});
        end
      endcase
    end

    // R12 mask write without bit 31 is ignored; with bit 31 it handshakes
    step(10'h000, 1'b1, 8'h20, 32'h00000005);
    chkReg("R12 ignored", 8'h20, 32'h0000000F);
    step(10'h000, 1'b1, 8'h20, 32'h80000002);
    chkReg("R12 pending", 8'h20, 32'h8000000F);
    step(10'h000, 1'b0, 8'h00, 32'h0);
    chkReg("R12 acked", 8'h20, 32'h40000002);

    // R4 masked-out wake line does not abort
    step(10'h000, 1'b1, 8'h00, 32'h80000000);
    step(10'h001, 1'b0, 8'h00, 32'h0);
    chkReg("R4 masked wake", 8'h00, 32'h40000000);

    // R8 wake after prepare blocks the gate
    step(10'h002, 1'b0, 8'h00, 32'h0);
    chkReg("R8 wake flag", 8'h00, 32'h40001000);
    step(10'h000, 1'b1, 8'h04, 32'h80000000);
    step(10'h000, 1'b0, 8'h00, 32'h0);
    chkReg("R8 gate ack", 8'h04, 32'h40000000);
    step(10'h200, 1'b0, 8'h00, 32'h0);
    chk("R8 no gate", {63'h0, pgEnable}, 64'h0);
    step(10'h000, 1'b1, 8'h00, 32'h20000000);
    step(10'h000, 1'b0, 8'h00, 32'h0);

    // R6 gate errors
    step(10'h000, 1'b1, 8'h20, 32'h8000000F);
    step(10'h000, 1'b0, 8'h00, 32'h0);
    step(10'h000, 1'b1, 8'h00, 32'h80000000);
    step(10'h000, 1'b0, 8'h00, 32'h0);
    chkReg("R2 clean prepare", 8'h00, 32'h40000000);
    step(10'h000, 1'b1, 8'h04, 32'h80000000);
    step(10'h120, 1'b0, 8'h00, 32'h0);
    chkReg("R6 gate flags", 8'h04, 32'h40014000);
    step(10'h200, 1'b0, 8'h00, 32'h0);
    chk("R6 no gate", {63'h0, pgEnable}, 64'h0);

    // R9 gate disable
    step(10'h000, 1'b1, 8'h04, 32'h80000000);
    step(10'h000, 1'b0, 8'h00, 32'h0);
    step(10'h000, 1'b1, 8'h04, 32'h20000000);
    step(10'h000, 1'b0, 8'h00, 32'h0);
    chkReg("R9 disable ack", 8'h04, 32'h10000000);
    step(10'h200, 1'b0, 8'h00, 32'h0);
    chk("R9 no gate", {63'h0, pgEnable}, 64'h0);

    // R11 resume address
    step(10'h000, 1'b1, 8'h10, 32'h80001234);
    chk("R11 high stays zero", resumeAddr, 64'h00000000_80001234);
    step(10'h000, 1'b1, 8'h14, 32'h00000009);
    chk("R11 resumeAddr", resumeAddr, 64'h00000009_80001234);
    chkReg("R11 low read", 8'h10, 32'h80001234);

    // R10 release delay and resume pulse
    step(10'h000, 1'b1, 8'h04, 32'h80000000);
    step(10'h000, 1'b0, 8'h00, 32'h0);
    step(10'h200, 1'b0, 8'h00, 32'h0);
    chk("R7 gate applied", {63'h0, pgEnable}, 64'h1);
    step(10'h201, 1'b0, 8'h00, 32'h0);
    for (int k = 0; k < 3; k++) step(10'h200, 1'b0, 8'h00, 32'h0);
    chk("R10 held", {62'h0, pgEnable, resumeValid}, 64'h2);
    step(10'h200, 1'b0, 8'h00, 32'h0);
    chk("R10 release pulse", {62'h0, pgEnable, resumeValid}, 64'h1);
    step(10'h000, 1'b0, 8'h00, 32'h0);
    chk("R10 pulse ends", {63'h0, resumeValid}, 64'h0);

    // R3 power-manager enable error and deny
    step(10'h000, 1'b1, 8'h00, 32'h80000000);
    step(10'h030, 1'b0, 8'h00, 32'h0);
    chkReg("R3 pm flags", 8'h00, 32'h40030000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule